// File: doc/BRIEF.md
# Multi-format serial audio receiver

This block turns a stereo serial audio stream into parallel left and right sample words. It is a slave to both the bit clock and the frame clock. All three serial lines are oversampled in one fast system clock domain. A half-frame is the run of bit-clock periods between two frame-clock edges. Each half-frame carries one channel. When a stereo pair is complete, the block presents it on two 24-bit output words and pulses a one-cycle strobe.

A 3-bit select picks the layout. Three layouts are LSB-justified, with 16, 20 or 24 data bits. One is MSB-justified with 20 bits. One is the I2S-style layout, where the sample starts one bit period after the frame edge. The select is taken only while the active-low power-down is held low. The same power-down input also clears the receiver. Samples always arrive MSB first in two's complement. They are presented left-aligned in a 24-bit word, with zeros in the unused low bits.

Top module: `ser_audio_rx`

## Requirements
- R1: While `pd_n` is low, `left_o`, `right_o` and `valid_o` are all zero.
- R2: `fmt_sel` is captured only while `pd_n` is low. Changes to it while `pd_n` is high have no effect on how later half-frames are decoded.
- R3: The select encodings are: 0 = 16-bit LSB-justified, 1 = 20-bit LSB-justified, 2 = 20-bit MSB-justified, 3 = I2S-style, 4 = 24-bit LSB-justified. The values 5, 6 and 7 behave exactly as 0.
- R4: A serial bit is taken at each rising bit-clock edge, using the frame-clock and data levels present at that edge. Bits arrive MSB first.
- R5: In the LSB-justified layouts, the sample is the last W bits of its half-frame (W = 16, 20 or 24). All earlier bits of the half-frame are ignored.
- R6: In the MSB-justified layout, the sample is the first 20 bits of its half-frame. Any later bits of the half-frame are ignored.
- R7: In the I2S-style layout, bit 0 of a half-frame is ignored and the MSB is bit 1. The sample width is the half-frame length, capped at 20 bits. When the half-frame has 20 or fewer bits, the LSB is the first bit of the following half-frame.
- R8: In the justified layouts, a high frame clock marks the left channel. In the I2S-style layout, a low frame clock marks the left channel.
- R9: Output words are 24 bits wide. The sample sits in the top bits and the unused low bits are zero.
- R10: `valid_o` rises for exactly one cycle, shortly after the frame edge that ends a right half-frame. This happens only when the left half-frame just before it was complete. The partial half-frame after power-down never produces output, and neither does a right half-frame with no complete left half-frame before it.
- R11: Between strobes, `left_o` and `right_o` hold the last presented pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample all serial lines |
| pd_n | input | 1 | Active-low power-down and reset; also enables format capture |
| bclk | input | 1 | Serial bit clock |
| fclk | input | 1 | Frame (channel) clock |
| sdata | input | 1 | Serial audio data |
| fmt_sel | input | 3 | Layout select, captured during power-down |
| left_o | output | 24 | Left sample, left-aligned |
| right_o | output | 24 | Right sample, left-aligned |
| valid_o | output | 1 | One-cycle strobe for a new stereo pair |

## Verification
Every layout is driven with samples whose MSB is set, samples with alternating patterns, and all-ones or single-bit values. Left and right always carry different values, so a channel swap, a bit-order error or a one-bit slip shows up as a wrong word. The don't-care positions are filled with ones-heavy junk, which exposes any window placed at the wrong end of a half-frame. The MSB-justified layout is run with 40 and 64 bit clocks per frame, and the I2S-style layout with 40 and 32, to separate fixed-width decoding from decoding that depends on the half-frame length. Further runs cover the following:
- a reserved select value;
- a select change while running;
- a leading right half-frame that has no left partner.

// File: rtl/sarx_pkg.sv
package sarx_pkg;

  localparam int SLOT_MAX = 32;
  localparam int CNT_W    = $clog2(SLOT_MAX + 1);
  localparam int WORD_W   = 24;
  localparam int WIDE_W   = 64;

  typedef enum logic [2:0] {
    FMT_RJ16 = 3'd0,
    FMT_RJ20 = 3'd1,
    FMT_LJ20 = 3'd2,
    FMT_I2S  = 3'd3,
    FMT_RJ24 = 3'd4
  } fmt_e;

  // Reserved encodings fall back to the 16-bit LSB-justified layout.
  function automatic fmt_e decode_fmt(input logic [2:0] sel);
    fmt_e f;
    case (sel)
      3'd1:    f = FMT_RJ20;
      3'd2:    f = FMT_LJ20;
      3'd3:    f = FMT_I2S;
      3'd4:    f = FMT_RJ24;
      default: f = FMT_RJ16;
    endcase
    return f;
  endfunction

  // Take the low w bits of v and place them at the top of an output word.
  function automatic logic [WORD_W-1:0] align_top(input logic [WIDE_W-1:0] v, input int w);
    logic [WIDE_W-1:0] t;
    if (w <= 0) t = '0;
    else        t = v << (WIDE_W - w);
    return t[WIDE_W-1 -: WORD_W];
  endfunction

  // sr holds the n bits of the finished half-frame (oldest highest).
  // nb is the bit taken at the frame edge that closed it.
  function automatic logic [WORD_W-1:0] pick_word(input fmt_e f,
                                                  input logic [SLOT_MAX-1:0] sr,
                                                  input logic nb,
                                                  input logic [CNT_W-1:0] n);
    logic [WIDE_W-1:0] plain;
    logic [WIDE_W-1:0] ext;
    logic [WORD_W-1:0] res;
    int cnt;
    plain = WIDE_W'(sr);
    ext   = WIDE_W'({sr, nb});
    cnt   = int'(n);
    case (f)
      FMT_RJ20: res = align_top(plain, 20);
      FMT_RJ24: res = align_top(plain, 24);
      FMT_LJ20: res = (cnt >= 20) ? align_top(plain >> (cnt - 20), 20) : align_top(plain, cnt);
      FMT_I2S:  res = (cnt <= 20) ? align_top(ext, cnt) : align_top(ext >> (cnt - 20), 20);
      default:  res = align_top(plain, 16);
    endcase
    return res;
  endfunction

endpackage

// File: rtl/sarx_sync.sv
module sarx_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    logic [WIDTH-1:0] r;
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r <= '0;
        else        r <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r <= '0;
        else        r <= g_stage[g-1].r;
      end
    end
  end

  assign q = g_stage[STAGES-1].r;

endmodule

// File: rtl/sarx_slot.sv
module sarx_slot
  import sarx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_tick,
  input  logic              lr_in,
  input  logic              dat_in,
  input  fmt_e              fmt,
  output logic              slot_done,
  output logic              slot_lr,
  output logic [WORD_W-1:0] slot_word
);

  logic                primed;
  logic                started;
  logic                lr_prev;
  logic [CNT_W-1:0]    cnt;
  logic [SLOT_MAX-1:0] sr;
  logic                boundary;

  assign boundary  = bit_tick && primed && (lr_in != lr_prev);
  assign slot_done = boundary && started;
  assign slot_lr   = lr_prev;
  assign slot_word = pick_word(fmt, sr, dat_in, cnt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      primed  <= 1'b0;
      started <= 1'b0;
      lr_prev <= 1'b0;
      cnt     <= '0;
      sr      <= '0;
    end else if (bit_tick) begin
      primed  <= 1'b1;
      lr_prev <= lr_in;
      if (boundary) begin
        started <= 1'b1;
        cnt     <= CNT_W'(1);
        sr      <= SLOT_MAX'(dat_in);
      end else begin
        sr <= {sr[SLOT_MAX-2:0], dat_in};
        if (cnt != CNT_W'(SLOT_MAX)) cnt <= cnt + CNT_W'(1);
      end
    end
  end

endmodule

// File: rtl/sarx_pair.sv
module sarx_pair
  import sarx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slot_done,
  input  logic              slot_lr,
  input  logic [WORD_W-1:0] slot_word,
  input  fmt_e              fmt,
  output logic [WORD_W-1:0] left_o,
  output logic [WORD_W-1:0] right_o,
  output logic              valid_o
);

  logic              is_left;
  logic              have_left;
  logic [WORD_W-1:0] held_left;

  assign is_left = (fmt == FMT_I2S) ? !slot_lr : slot_lr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have_left <= 1'b0;
      held_left <= '0;
      left_o    <= '0;
      right_o   <= '0;
      valid_o   <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (slot_done) begin
        if (is_left) begin
          held_left <= slot_word;
          have_left <= 1'b1;
        end else if (have_left) begin
          left_o    <= held_left;
          right_o   <= slot_word;
          valid_o   <= 1'b1;
          have_left <= 1'b0;
        end
      end
    end
  end

endmodule

// File: rtl/ser_audio_rx.sv
module ser_audio_rx
  import sarx_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              pd_n,
  input  logic              bclk,
  input  logic              fclk,
  input  logic              sdata,
  input  logic [2:0]        fmt_sel,
  output logic [WORD_W-1:0] left_o,
  output logic [WORD_W-1:0] right_o,
  output logic              valid_o
);

  localparam int LINES = 3;

  logic [LINES-1:0]  raw_lines;
  logic [LINES-1:0]  sync_lines;
  logic              bclk_s;
  logic              fclk_s;
  logic              sdata_s;
  logic              bclk_d;
  logic              bit_tick;
  fmt_e              fmt_q;
  logic              slot_done;
  logic              slot_lr;
  logic [WORD_W-1:0] slot_word;

  assign raw_lines = {bclk, fclk, sdata};

  sarx_sync #(.WIDTH(LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (pd_n),
    .d     (raw_lines),
    .q     (sync_lines)
  );

  assign {bclk_s, fclk_s, sdata_s} = sync_lines;

  always_ff @(posedge clk or negedge pd_n) begin
    if (!pd_n) bclk_d <= 1'b0;
    else       bclk_d <= bclk_s;
  end

  assign bit_tick = bclk_s && !bclk_d;

  // The layout is taken only while the block is powered down.
  always_ff @(posedge clk) begin
    if (!pd_n) fmt_q <= decode_fmt(fmt_sel);
  end

  sarx_slot u_slot (
    .clk       (clk),
    .rst_n     (pd_n),
    .bit_tick  (bit_tick),
    .lr_in     (fclk_s),
    .dat_in    (sdata_s),
    .fmt       (fmt_q),
    .slot_done (slot_done),
    .slot_lr   (slot_lr),
    .slot_word (slot_word)
  );

  sarx_pair u_pair (
    .clk       (clk),
    .rst_n     (pd_n),
    .slot_done (slot_done),
    .slot_lr   (slot_lr),
    .slot_word (slot_word),
    .fmt       (fmt_q),
    .left_o    (left_o),
    .right_o   (right_o),
    .valid_o   (valid_o)
  );

endmodule

// File: rtl/sarx_chk.sv
module sarx_chk
  import sarx_pkg::*;
(
  input logic              clk,
  input logic              pd_n,
  input logic [2:0]        fmt_sel,
  input fmt_e              fmt_q,
  input logic              slot_done,
  input logic [WORD_W-1:0] left_o,
  input logic [WORD_W-1:0] right_o,
  input logic              valid_o
);

  always @(posedge clk) begin
    if (!pd_n) begin
      a_r1_pd_quiet: assert (!valid_o && left_o == '0 && right_o == '0);
    end
  end

  a_r2_fmt_held: assert property (@(posedge clk) disable iff (!pd_n)
    $past(pd_n) |-> $stable(fmt_q));

  a_r3_reserved_map: assert property (@(posedge clk) disable iff (!pd_n)
    (!$past(pd_n) && $past(fmt_sel) >= 3'd5) |-> (fmt_q == FMT_RJ16));

  a_r9_low_zero: assert property (@(posedge clk) disable iff (!pd_n)
    (valid_o && fmt_q == FMT_RJ16) |-> (left_o[7:0] == 8'd0 && right_o[7:0] == 8'd0));

  a_r10_single_pulse: assert property (@(posedge clk) disable iff (!pd_n)
    valid_o |=> !valid_o);

  a_r10_after_boundary: assert property (@(posedge clk) disable iff (!pd_n)
    valid_o |-> $past(slot_done));

  a_r11_hold: assert property (@(posedge clk) disable iff (!pd_n)
    !valid_o |-> ($stable(left_o) && $stable(right_o)));

endmodule

bind ser_audio_rx sarx_chk u_chk (
  .clk       (clk),
  .pd_n      (pd_n),
  .fmt_sel   (fmt_sel),
  .fmt_q     (fmt_q),
  .slot_done (slot_done),
  .left_o    (left_o),
  .right_o   (right_o),
  .valid_o   (valid_o)
);

// File: tb/tb_ser_audio_rx.sv
module tb_ser_audio_rx;

  localparam int CLK_PERIOD = 10;
  localparam int BIT_HALF   = 4;
  localparam int WATCHDOG   = 200000;

  logic        clk = 1'b0;
  logic        pd_n = 1'b0;
  logic        bclk = 1'b0;
  logic        fclk = 1'b0;
  logic        sdata = 1'b0;
  logic [2:0]  fmt_sel = 3'd0;
  logic [23:0] left_o;
  logic [23:0] right_o;
  logic        valid_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  ser_audio_rx dut (
    .clk     (clk),
    .pd_n    (pd_n),
    .bclk    (bclk),
    .fclk    (fclk),
    .sdata   (sdata),
    .fmt_sel (fmt_sel),
    .left_o  (left_o),
    .right_o (right_o),
    .valid_o (valid_o)
  );

  typedef struct {
    logic [23:0] l;
    logic [23:0] r;
    string       req;
  } exp_t;

  exp_t        sb[$];
  int          total = 0;
  int          bad = 0;
  logic        carry = 1'b0;
  int          junk_k = 0;
  logic [23:0] last_l = '0;
  logic [23:0] last_r = '0;
  bit          done = 1'b0;

  task automatic check(input string req, input logic [23:0] act, input logic [23:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Monitor: compare every strobe against the oldest expected pair.
  always @(negedge clk) begin
    if (pd_n && valid_o) begin
      if (sb.size() == 0) begin
        total++;
        bad++;
        $display("FAIL R10 actual=unexpected strobe expected=none");
      end else begin
        exp_t e;
        e = sb.pop_front();
        check({e.req, " left"}, left_o, e.l);
        check({e.req, " right"}, right_o, e.r);
      end
    end
  end

  function automatic logic junk_bit();
    junk_k++;
    return (junk_k % 3) != 0;
  endfunction

  task automatic drive_bit(input logic lr, input logic b);
    fclk  = lr;
    sdata = b;
    bclk  = 1'b0;
    repeat (BIT_HALF) @(negedge clk);
    bclk = 1'b1;
    repeat (BIT_HALF) @(negedge clk);
  endtask

  // mode: 0/1/4 LSB-justified, 2 MSB-justified, 3 I2S-style
  task automatic send_half(input int mode, input int n, input logic lr,
                           input logic [23:0] smp, input int w);
    logic next_carry;
    next_carry = junk_bit();
    for (int k = 0; k < n; k++) begin
      logic b;
      b = junk_bit();
      if (mode == 2) begin
        if (k < w) b = smp[w-1-k];
      end else if (mode == 3) begin
        if (k == 0) b = carry;
        else if (k <= w) b = smp[w-k];
        if (w == n) next_carry = smp[0];
      end else begin
        if (k >= n - w) b = smp[n-1-k];
      end
      drive_bit(lr, b);
    end
    carry = next_carry;
  endtask

  task automatic send_frame(input int mode, input int n, input int w,
                            input logic [23:0] ls, input logic [23:0] rs, input string req);
    exp_t e;
    logic left_lvl;
    left_lvl = (mode == 3) ? 1'b0 : 1'b1;
    e.l = ls << (24 - w);
    e.r = rs << (24 - w);
    e.req = req;
    last_l = e.l;
    last_r = e.r;
    sb.push_back(e);
    send_half(mode, n, left_lvl, ls, w);
    send_half(mode, n, !left_lvl, rs, w);
  endtask

  task automatic start_run(input logic [2:0] sel, input int mode, input bit prime_left);
    logic left_lvl;
    left_lvl = (mode == 3) ? 1'b0 : 1'b1;
    @(negedge clk);
    pd_n = 1'b0;
    fmt_sel = sel;
    bclk = 1'b0;
    repeat (6) @(negedge clk);
    check("R1 left in power-down", left_o, 24'd0);
    check("R1 right in power-down", right_o, 24'd0);
    check("R1 strobe in power-down", {23'd0, valid_o}, 24'd0);
    pd_n = 1'b1;
    repeat (3) @(negedge clk);
    carry = junk_bit();
    drive_bit(prime_left ? left_lvl : !left_lvl, junk_bit());
    drive_bit(prime_left ? left_lvl : !left_lvl, junk_bit());
  endtask

  task automatic end_run(input int mode, input int n, input int w);
    logic left_lvl;
    left_lvl = (mode == 3) ? 1'b0 : 1'b1;
    send_half(mode, n, left_lvl, 24'd0, w);
    repeat (8) @(negedge clk);
    check("R10 pending pairs", 24'(sb.size()), 24'd0);
    check("R11 left held", left_o, last_l);
    check("R11 right held", right_o, last_r);
  endtask

  initial begin
    repeat (3) @(negedge clk);

    // 16-bit LSB-justified at 32 bit clocks per frame
    start_run(3'd0, 0, 1'b0);
    send_frame(0, 16, 16, 24'h8001, 24'h7FFE, "R5 R9 rj16");
    send_frame(0, 16, 16, 24'h1234, 24'hFFFF, "R4 R8 rj16");
    end_run(0, 16, 16);

    // 20-bit LSB-justified at 40 bit clocks per frame
    start_run(3'd1, 1, 1'b0);
    send_frame(1, 20, 20, 24'hABCDE, 24'h00001, "R5 rj20");
    send_frame(1, 20, 20, 24'h80000, 24'h5A5A5, "R5 rj20 msb");
    end_run(1, 20, 20);

    // 24-bit LSB-justified at 48 bit clocks per frame
    start_run(3'd4, 4, 1'b0);
    send_frame(4, 24, 24, 24'h800001, 24'h123456, "R5 rj24");
    end_run(4, 24, 24);

    // 20-bit MSB-justified, 40 and 64 bit clocks, select changed while running
    start_run(3'd2, 2, 1'b0);
    send_frame(2, 20, 20, 24'h9C3A1, 24'h0F0F0, "R6 lj20 40fs");
    fmt_sel = 3'd1;
    send_frame(2, 32, 20, 24'hFFFFF, 24'h40002, "R2 R6 lj20 64fs");
    send_frame(2, 32, 20, 24'h00003, 24'hC0000, "R2 R6 lj20 64fs");
    end_run(2, 32, 20);

    // I2S-style at 40 bit clocks (20-bit)
    start_run(3'd3, 3, 1'b0);
    send_frame(3, 20, 20, 24'hC0001, 24'h3FFFE, "R7 R8 i2s20");
    send_frame(3, 20, 20, 24'h00002, 24'hA5A5A, "R7 i2s20");
    end_run(3, 20, 20);

    // I2S-style at 32 bit clocks (16-bit)
    start_run(3'd3, 3, 1'b0);
    send_frame(3, 16, 16, 24'h8000, 24'h0001, "R7 i2s16");
    send_frame(3, 16, 16, 24'h7FFF, 24'hFFFE, "R7 R8 i2s16");
    end_run(3, 16, 16);

    // Reserved select, plus an orphan right half-frame after priming
    start_run(3'd5, 0, 1'b1);
    send_half(0, 16, 1'b0, 24'h5555, 16);
    send_frame(0, 16, 16, 24'hBEEF, 24'hCAFE, "R3 R10 reserved");
    end_run(0, 16, 16);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule